// File: doc/BRIEF.md
# Variable-Length Instruction Byte Collector

The collector sits behind an instruction byte fetch path of a processor with a 16-bit instruction set. It takes one byte per cycle in which `byte_vld_i` is high and assembles one instruction at a time. The first byte is the opcode. Its two top bits select one of four groups through a small lookup table, and the group, together with the addressing byte that follows, fixes the format class. The class tells how many displacement and immediate bytes are still to come.

When the last byte of an instruction is accepted, the collector presents the decoded fields on its outputs in the next cycle and raises `done_o` for that one cycle. The fields are the opcode, the width bit, the three addressing fields, an extension field, a 16-bit displacement, 16-bit immediate data, the format class and the total length in bytes. The outputs then hold their values until the next completion. A byte offered in the cycle that `done_o` is high is already part of the next instruction, so a continuous stream runs with no idle cycles between instructions.

Top module: `ibc_collector`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) drops any partial instruction, makes the next accepted byte an opcode, and clears `done_o`, `len_o`, `fmt_o` and every field output to zero.
- R2: Opcode bits 7:6 select the group through the default table: 00 single byte, 01 addressing-byte form, 10 immediate to register, 11 immediate to memory. `fmt_o` reports the class as 0 single byte, 1 register to register, 2 memory with no displacement, 3 memory with displacement, 4 immediate to register, 5 immediate to memory.
- R3: A single-byte instruction has length 1, and `reg_o` carries opcode bits 2:0. `mod_o`, `rm_o`, `ext_o`, `disp_o` and `imm_o` are zero.
- R4: In the addressing-byte group, the second byte gives `mod_o` from bits 7:6, `reg_o` from bits 5:3 and `rm_o` from bits 2:0. A MOD of 11 gives class 1 and a MOD of 00 gives class 2, both with length 2. A MOD of 01 or 10 gives class 3 with length 4, and the two displacement bytes arrive low byte first.
- R5: `wide_o` is opcode bit 0. An immediate-to-register instruction is 3 bytes long with an 8-bit immediate when the width bit is 0 (upper `imm_o` byte zero), and 4 bytes long with a 16-bit immediate, low byte first, when the width bit is 1. The second byte is decoded as in R4.
- R6: An immediate-to-memory instruction carries a 2-byte displacement, low byte first, followed by the immediate (1 byte if the width bit is 0, else 2 bytes low first), for a length of 5 or 6. Bits 5:3 of its second byte appear on `ext_o`, and `reg_o` is zero.
- R7: `done_o` is high for exactly one cycle per instruction: the cycle after the last byte is accepted. All outputs keep their values while `done_o` is low.
- R8: A byte accepted in a cycle where `done_o` is high is the opcode of the next instruction. Back-to-back single-byte instructions give `done_o` on consecutive cycles.
- R9: Cycles with `byte_vld_i` low are ignored whatever `byte_i` holds, so gaps inside an instruction do not change its result.
- R10: Fields the format does not carry read zero. `disp_o` is zero unless the class is 3 or 5, and `imm_o` is zero unless the class is 4 or 5, even right after an instruction that set them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| byte_vld_i | input | 1 | Byte on `byte_i` is offered this cycle |
| byte_i | input | 8 | Instruction stream byte |
| done_o | output | 1 | One-cycle pulse: a complete instruction is on the outputs |
| fmt_o | output | 3 | Format class (encoding in R2) |
| opcode_o | output | 8 | First byte of the instruction |
| wide_o | output | 1 | Width bit: 0 byte operand, 1 word operand |
| mod_o | output | 2 | MOD field of the addressing byte |
| reg_o | output | 3 | Register field |
| rm_o | output | 3 | R/M field |
| ext_o | output | 3 | Opcode extension bits of the immediate-to-memory form |
| disp_o | output | 16 | Displacement |
| imm_o | output | 16 | Immediate data |
| len_o | output | 3 | Total instruction length in bytes |

## Verification
Every class is driven: a lone opcode, each of the four MOD values in the addressing-byte group, and both widths of the two immediate groups. Together these separate the length rules that depend on MOD from those that depend on the width bit. Displacement and immediate bytes have distinct values, so a swapped byte order or a displacement byte misplaced into the immediate shows up. A long instruction is repeated with idle gaps that carry junk data. Short instructions are run back to back, with a 2-byte form followed at once by a 4-byte one, to show that no bubble is inserted and that stale fields are cleared. A reset in the middle of an instruction shows that the partial bytes are dropped.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

   typedef enum logic [2:0] {
      FMT_ONE  = 3'd0,
      FMT_RR   = 3'd1,
      FMT_MEM  = 3'd2,
      FMT_MEMD = 3'd3,
      FMT_IMMR = 3'd4,
      FMT_IMMM = 3'd5
   } fmt_e;

   typedef enum logic [1:0] {
      GRP_ONE   = 2'd0,
      GRP_MODRM = 2'd1,
      GRP_IMMR  = 2'd2,
      GRP_IMMM  = 2'd3
   } grp_e;

   // group code per opcode[7:6], entry i at bits 2i+1:2i
   localparam logic [7:0] DEFAULT_GROUP_MAP = 8'b11_10_01_00;

   function automatic logic [1:0] disp_count(input fmt_e f);
      return (f == FMT_MEMD || f == FMT_IMMM) ? 2'd2 : 2'd0;
   endfunction

endpackage

// File: rtl/ibc_classify.sv
module ibc_classify
   import ibc_pkg::*;
#(
   parameter logic [7:0] GROUP_MAP = DEFAULT_GROUP_MAP,
   parameter int         LEN_W     = 3
) (
   input  logic [1:0]       opc_top_i,
   input  logic             wide_i,
   input  logic [1:0]       mod_i,
   output fmt_e             fmt_o,
   output logic [LEN_W-1:0] len_o,
   output logic [1:0]       ndisp_o
);

   grp_e       grp;
   logic [2:0] map_idx;

   assign map_idx = {opc_top_i, 1'b0};

   always_comb begin
      grp = grp_e'(GROUP_MAP[map_idx +: 2]);
      case (grp)
         GRP_ONE:   fmt_o = FMT_ONE;
         GRP_MODRM: begin
            case (mod_i)
               2'b11:   fmt_o = FMT_RR;
               2'b00:   fmt_o = FMT_MEM;
               default: fmt_o = FMT_MEMD;
            endcase
         end
         GRP_IMMR:  fmt_o = FMT_IMMR;
         default:   fmt_o = FMT_IMMM;
      endcase
   end

   always_comb begin
      case (fmt_o)
         FMT_ONE:            len_o = LEN_W'(3'd1);
         FMT_RR, FMT_MEM:    len_o = LEN_W'(3'd2);
         FMT_MEMD:           len_o = LEN_W'(3'd4);
         FMT_IMMR:           len_o = wide_i ? LEN_W'(3'd4) : LEN_W'(3'd3);
         FMT_IMMM:           len_o = wide_i ? LEN_W'(3'd6) : LEN_W'(3'd5);
         default:            len_o = LEN_W'(3'd1);
      endcase
   end

   assign ndisp_o = disp_count(fmt_o);

   always_comb begin
      // R5 R6: immediate groups never shorter than three bytes
      AST_IMM_MIN_LEN: assert (!(fmt_o == FMT_IMMR || fmt_o == FMT_IMMM) || len_o >= LEN_W'(3'd3)); // R5
   end

endmodule

// File: rtl/ibc_seq.sv
module ibc_seq #(
   parameter int MAX_BYTES = 6,
   parameter int LEN_W     = 3
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             vld_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] pos_o,
   output logic             last_o,
   output logic             done_o
);

   logic [LEN_W-1:0] pos_q;

   assign pos_o  = pos_q;
   assign last_o = (pos_q + LEN_W'(1)) == len_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= vld_i && last_o;
         if (vld_i)
            pos_q <= last_o ? '0 : pos_q + LEN_W'(1);
      end
   end

   AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      pos_q < LEN_W'(MAX_BYTES)); // R7

   AST_DONE_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> $past(vld_i)); // R8

   AST_IDLE_NO_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
      !vld_i |=> !done_o); // R9

endmodule

// File: rtl/ibc_collector.sv
module ibc_collector
   import ibc_pkg::*;
#(
   parameter int         BYTE_W    = 8,
   parameter int         MAX_BYTES = 6,
   parameter logic [7:0] GROUP_MAP = DEFAULT_GROUP_MAP,
   localparam int        LEN_W     = $clog2(MAX_BYTES + 1),
   localparam int        LANES     = 2,
   localparam int        FIELD_W   = LANES * BYTE_W
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               byte_vld_i,
   input  logic [BYTE_W-1:0]  byte_i,
   output logic               done_o,
   output logic [2:0]         fmt_o,
   output logic [BYTE_W-1:0]  opcode_o,
   output logic               wide_o,
   output logic [1:0]         mod_o,
   output logic [2:0]         reg_o,
   output logic [2:0]         rm_o,
   output logic [2:0]         ext_o,
   output logic [FIELD_W-1:0] disp_o,
   output logic [FIELD_W-1:0] imm_o,
   output logic [LEN_W-1:0]   len_o
);

   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("ibc_collector: BYTE_W must be 8");
   end
   if (MAX_BYTES < 6) begin : g_bad_max
      $error("ibc_collector: MAX_BYTES must cover the 6-byte form");
   end

   logic [BYTE_W-1:0]  opc_q, mrm_q, opc_cur, mrm_cur;
   logic [FIELD_W-1:0] disp_q, imm_q, disp_base, imm_base, disp_nx, imm_nx;
   logic [LEN_W-1:0]   pos, len_cur, body_idx, imm_idx;
   logic [1:0]         ndisp;
   logic               last, wr_body, in_disp;
   fmt_e               fmt_cur;
   logic [1:0]         mod_nx;
   logic [2:0]         reg_nx, rm_nx, ext_nx;

   assign opc_cur = (pos == '0)          ? byte_i : opc_q;
   assign mrm_cur = (pos == LEN_W'(1))   ? byte_i : mrm_q;

   ibc_classify #(.GROUP_MAP(GROUP_MAP), .LEN_W(LEN_W)) u_cls (
      .opc_top_i (opc_cur[7:6]),
      .wide_i    (opc_cur[0]),
      .mod_i     (mrm_cur[7:6]),
      .fmt_o     (fmt_cur),
      .len_o     (len_cur),
      .ndisp_o   (ndisp)
   );

   ibc_seq #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_seq (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .vld_i  (byte_vld_i),
      .len_i  (len_cur),
      .pos_o  (pos),
      .last_o (last),
      .done_o (done_o)
   );

   // byte placement after opcode and addressing byte
   assign wr_body   = byte_vld_i && (pos >= LEN_W'(2));
   assign body_idx  = pos - LEN_W'(2);
   assign in_disp   = body_idx < LEN_W'(ndisp);
   assign imm_idx   = body_idx - LEN_W'(ndisp);
   assign disp_base = (pos == '0) ? '0 : disp_q;
   assign imm_base  = (pos == '0) ? '0 : imm_q;

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      assign disp_nx[L*BYTE_W +: BYTE_W] =
         (wr_body && in_disp && body_idx == LEN_W'(L)) ? byte_i : disp_base[L*BYTE_W +: BYTE_W];
      assign imm_nx[L*BYTE_W +: BYTE_W] =
         (wr_body && !in_disp && imm_idx == LEN_W'(L)) ? byte_i : imm_base[L*BYTE_W +: BYTE_W];
   end

   always_comb begin
      if (fmt_cur == FMT_ONE) begin
         mod_nx = 2'b00;
         rm_nx  = 3'b000;
         reg_nx = opc_cur[2:0];
         ext_nx = 3'b000;
      end else begin
         mod_nx = mrm_cur[7:6];
         rm_nx  = mrm_cur[2:0];
         reg_nx = (fmt_cur == FMT_IMMM) ? 3'b000 : mrm_cur[5:3];
         ext_nx = (fmt_cur == FMT_IMMM) ? mrm_cur[5:3] : 3'b000;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         opc_q  <= '0;
         mrm_q  <= '0;
         disp_q <= '0;
         imm_q  <= '0;
      end else if (byte_vld_i) begin
         if (pos == '0)        opc_q <= byte_i;
         if (pos == LEN_W'(1)) mrm_q <= byte_i;
         disp_q <= disp_nx;
         imm_q  <= imm_nx;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         fmt_o    <= '0;
         opcode_o <= '0;
         wide_o   <= 1'b0;
         mod_o    <= '0;
         reg_o    <= '0;
         rm_o     <= '0;
         ext_o    <= '0;
         disp_o   <= '0;
         imm_o    <= '0;
         len_o    <= '0;
      end else if (byte_vld_i && last) begin
         fmt_o    <= fmt_cur;
         opcode_o <= opc_cur;
         wide_o   <= opc_cur[0];
         mod_o    <= mod_nx;
         reg_o    <= reg_nx;
         rm_o     <= rm_nx;
         ext_o    <= ext_nx;
         disp_o   <= disp_nx;
         imm_o    <= imm_nx;
         len_o    <= len_cur;
      end
   end

   AST_SINGLE_SHAPE: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && fmt_o == FMT_ONE) |-> (len_o == LEN_W'(1) && mod_o == 2'b00 && rm_o == 3'b000)); // R3

   AST_IMMM_SHAPE: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && fmt_o == FMT_IMMM) |-> (reg_o == 3'b000 && (len_o == LEN_W'(5) || len_o == LEN_W'(6)))); // R6

   AST_HOLD_OUTPUTS: assert property (@(posedge clk_i) disable iff (rst_i)
      !done_o |-> ($stable(len_o) && $stable(disp_o) && $stable(imm_o) && $stable(opcode_o))); // R7

   AST_NO_STRAY_DISP: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && fmt_o != FMT_MEMD && fmt_o != FMT_IMMM) |-> disp_o == '0); // R10

endmodule

// File: tb/tb_ibc_collector.sv
`timescale 1ns/1ps
module tb_ibc_collector;

   logic        clk = 1'b0;
   logic        rst;
   logic        vld;
   logic [7:0]  bin;
   logic        done;
   logic [2:0]  fmt, rg, rm, ext, len;
   logic [7:0]  opc;
   logic        wide;
   logic [1:0]  mod;
   logic [15:0] disp, imm;

   always #2.5 clk = ~clk;

   ibc_collector dut (
      .clk_i(clk), .rst_i(rst), .byte_vld_i(vld), .byte_i(bin),
      .done_o(done), .fmt_o(fmt), .opcode_o(opc), .wide_o(wide),
      .mod_o(mod), .reg_o(rg), .rm_o(rm), .ext_o(ext),
      .disp_o(disp), .imm_o(imm), .len_o(len)
   );

   typedef struct packed {
      logic [7:0]  opc;
      logic        w;
      logic [1:0]  mod;
      logic [2:0]  rg;
      logic [2:0]  rm;
      logic [2:0]  ext;
      logic [2:0]  cls;
      logic [15:0] disp;
      logic [15:0] imm;
      logic [2:0]  len;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  last_exp;
   int    n_run = 0, n_fail = 0;
   int    run_len = 0, max_run = 0;

   // expected result from the requirements (R2..R6, R10)
   function automatic exp_t model(input logic [7:0] b [6]);
      exp_t e;
      e = '0;
      e.opc = b[0];
      e.w   = b[0][0];
      case (b[0][7:6])
         2'b00: e.cls = 3'd0;
         2'b01: e.cls = (b[1][7:6] == 2'b11) ? 3'd1 : (b[1][7:6] == 2'b00) ? 3'd2 : 3'd3;
         2'b10: e.cls = 3'd4;
         default: e.cls = 3'd5;
      endcase
      case (e.cls)
         3'd0: e.len = 3'd1;
         3'd1, 3'd2: e.len = 3'd2;
         3'd3: e.len = 3'd4;
         3'd4: e.len = e.w ? 3'd4 : 3'd3;
         default: e.len = e.w ? 3'd6 : 3'd5;
      endcase
      if (e.cls == 3'd0) begin
         e.rg = b[0][2:0];
      end else begin
         e.mod = b[1][7:6];
         e.rm  = b[1][2:0];
         if (e.cls == 3'd5) e.ext = b[1][5:3];
         else               e.rg  = b[1][5:3];
      end
      if (e.cls == 3'd3 || e.cls == 3'd5) e.disp = {b[3], b[2]};
      if (e.cls == 3'd4) e.imm = e.w ? {b[3], b[2]} : {8'h00, b[2]};
      if (e.cls == 3'd5) e.imm = e.w ? {b[5], b[4]} : {8'h00, b[4]};
      return e;
   endfunction

   function automatic exp_t observed();
      exp_t g;
      g.opc = opc; g.w = wide; g.mod = mod; g.rg = rg; g.rm = rm;
      g.ext = ext; g.cls = fmt; g.disp = disp; g.imm = imm; g.len = len;
      return g;
   endfunction

   // monitor: compare each completion against the scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (done) begin
            run_len = run_len + 1;
            if (run_len > max_run) max_run = run_len;
            n_run = n_run + 1;
            if (exp_q.size() == 0) begin
               n_fail = n_fail + 1;
               $display("FAIL R7: unexpected done, got %h expected none", observed());
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               last_exp = e;
               if (observed() !== e) begin
                  n_fail = n_fail + 1;
                  $display("FAIL %s: got %h expected %h", t, observed(), e);
               end
            end
         end else begin
            run_len = 0;
         end
      end
   end

   // driver: push expectation, then offer the bytes
   task automatic send(input logic [7:0] b0, b1, b2, b3, b4, b5,
                       input int gap, input string tag);
      logic [7:0] b [6];
      exp_t e;
      b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3; b[4] = b4; b[5] = b5;
      e = model(b);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      for (int i = 0; i < int'(e.len); i++) begin
         @(negedge clk);
         vld = 1'b1;
         bin = b[i];
         if (i < int'(e.len) - 1) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               vld = 1'b0;
               bin = 8'hFF;
            end
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         vld = 1'b0;
         bin = 8'hA5;
      end
   endtask

   task automatic check_zero(input string tag);
      n_run = n_run + 1;
      if (done !== 1'b0 || observed() !== '0) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: got done=%b fields %h expected done=0 fields 0", tag, done, observed());
      end
   endtask

   task automatic check_hold(input string tag);
      n_run = n_run + 1;
      if (done !== 1'b0 || observed() !== last_exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: got done=%b fields %h expected done=0 fields %h", tag, done, observed(), last_exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got no end expected end of run");
      summary();
      $finish;
   end

   initial begin
      rst = 1'b1; vld = 1'b0; bin = 8'h00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      check_zero("R1 reset state");

      // R3 R2: single byte, REG from opcode bits 2:0
      send(8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R3 single byte");
      idle(3);
      // R4: all four MOD values
      send(8'h41, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R4 mod11 reg-reg");
      idle(2);
      send(8'h40, 8'h1A, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R4 mod00 no disp");
      idle(2);
      send(8'h41, 8'h9E, 8'h34, 8'h12, 8'h00, 8'h00, 0, "R4 mod10 disp");
      idle(2);
      send(8'h45, 8'h5E, 8'hCD, 8'hAB, 8'h00, 8'h00, 0, "R4 mod01 disp");
      idle(2);
      // R5: immediate to register, both widths
      send(8'h80, 8'hC1, 8'h7F, 8'h00, 8'h00, 8'h00, 0, "R5 imm8 to reg");
      idle(2);
      send(8'h81, 8'hCA, 8'h78, 8'h56, 8'h00, 8'h00, 0, "R5 imm16 to reg");
      idle(2);
      // R6: immediate to memory, both widths, extension bits
      send(8'hC0, 8'h2D, 8'h00, 8'h50, 8'h99, 8'h00, 0, "R6 imm8 to mem");
      idle(2);
      send(8'hC7, 8'h3E, 8'h11, 8'h22, 8'h33, 8'h44, 0, "R6 imm16 to mem");
      idle(4);
      #1;
      check_hold("R7 outputs held while idle");

      // R9: gaps with junk data inside an instruction
      send(8'hC7, 8'h3E, 8'h11, 8'h22, 8'h33, 8'h44, 3, "R9 gapped imm16 to mem");
      idle(2);
      send(8'h41, 8'h9E, 8'h34, 8'h12, 8'h00, 8'h00, 2, "R9 gapped disp form");
      idle(3);

      // R8: back-to-back single bytes
      send(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R8 stream byte 1");
      send(8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R8 stream byte 2");
      send(8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R8 stream byte 3");
      send(8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R8 stream byte 4");
      idle(3);
      n_run = n_run + 1;
      if (max_run < 4) begin
         n_fail = n_fail + 1;
         $display("FAIL R8: got %0d consecutive done cycles expected 4", max_run);
      end

      // R8 R10: displacement form, then reg-reg straight after; stale disp must clear
      send(8'h45, 8'h5E, 8'hEF, 8'hBE, 8'h00, 8'h00, 0, "R8 disp form in stream");
      send(8'h43, 8'hD8, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R10 disp cleared after disp form");
      send(8'h81, 8'hCA, 8'h0D, 8'hF0, 8'h00, 8'h00, 0, "R8 imm16 in stream");
      send(8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R10 imm cleared on single byte");
      idle(3);

      // R1: reset in the middle of an instruction
      @(negedge clk); vld = 1'b1; bin = 8'h81;
      @(negedge clk); vld = 1'b1; bin = 8'hC2;
      @(negedge clk); vld = 1'b0; rst = 1'b1;
      @(negedge clk);
      @(negedge clk); rst = 1'b0; #1;
      check_zero("R1 reset mid instruction");
      send(8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R1 first byte after reset is opcode");
      idle(4);

      n_run = n_run + 1;
      if (exp_q.size() != 0) begin
         n_fail = n_fail + 1;
         $display("FAIL R7: got %0d instructions without done expected 0", exp_q.size());
      end
      summary();
      $finish;
   end

endmodule